// File: doc/BRIEF.md
# I2C Pin Override Port

This block sits between an I2C protocol engine and the two open-drain bus pads. Normally the engine owns both pads and its output enables pass straight through. Software can take the pads over through a small 16-bit register bus, for example to clock a stuck target free during bus recovery. In that case it can drive each line low or release it, and it can read back both line levels.

One function bit moves both pads together. A direction bit per pad decides whether software drives it. The output level is changed only through write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write sequence. Pad levels reach software through a two-flop synchronizer per line. The pads are open-drain: a pad enable of 1 pulls the line low, and a released line floats high.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset the function, direction and output latch are zero, the pads follow the engine enables, and reads of every register return 0 until synchronized pad levels arrive.
- R2: While bit 0 of the function register (offset 0x48) is 0, pad_scl_oe equals eng_scl_oe and pad_sda_oe equals eng_sda_oe in the same cycle.
- R3: While function bit 0 is 1, both pads are under software control and the engine enables have no effect on them.
- R4: Under software control, a pad enable is 1 only when its direction bit (offset 0x4C, bit 0 SCL, bit 1 SDA) is 1 and its output latch bit is 0. A direction bit of 0 releases that pad.
- R5: A write to offset 0x58 sets each output latch bit (bit 0 SCL, bit 1 SDA) whose written bit is 1, and leaves bits written as 0 unchanged.
- R6: A write to offset 0x5C clears each output latch bit whose written bit is 1, and leaves bits written as 0 unchanged.
- R7: A read of offset 0x54 returns the output latch in bits 1:0. Writes to 0x54 and to the data-in offset 0x50 change no state.
- R8: A read of offset 0x50 returns the SCL level in bit 0 and the SDA level in bit 1, as sampled at the second rising edge after the pad value is presented.
- R9: Reads of the set, clear and unmapped offsets return 0. A read in the same cycle as a write returns the value from before that write.
- R10: Function bits above bit 0 and direction bits above bit 1 are discarded on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W (8) | Byte offset of the register being accessed |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for reg_addr, valid in the same cycle |
| eng_scl_oe | input | 1 | Engine pull-low request for SCL |
| eng_sda_oe | input | 1 | Engine pull-low request for SDA |
| pad_scl_i | input | 1 | SCL line level from the pad |
| pad_sda_i | input | 1 | SDA line level from the pad |
| pad_scl_oe | output | 1 | SCL pull-low enable to the pad |
| pad_sda_oe | output | 1 | SDA pull-low enable to the pad |

## Verification
Two things can happen in the same cycle: a register write that changes the function, direction or output latch, and a read of the same register or a change of the pad outputs. The bench holds the address steady while writing, so every write cycle is also a read. A behavioural model updates only at the clock edge, so the read must return the value from before the write. The pad outputs must change only in the cycle after the edge. The bench also toggles the engine enables and the pad levels in the same cycles as function and direction writes. Each cycle it compares both pad enables and the read data with the model.

// File: rtl/pinov_pkg.sv
package pinov_pkg;
    localparam int NPINS     = 2;
    localparam int PIN_SCL   = 0;
    localparam int PIN_SDA   = 1;

    localparam logic [7:0] OFS_FUNC = 8'h48;
    localparam logic [7:0] OFS_DIR  = 8'h4C;
    localparam logic [7:0] OFS_DIN  = 8'h50;
    localparam logic [7:0] OFS_DOUT = 8'h54;
    localparam logic [7:0] OFS_SET  = 8'h58;
    localparam logic [7:0] OFS_CLR  = 8'h5C;

    typedef struct packed {
        logic             sw_own;
        logic [NPINS-1:0] drive_en;
        logic [NPINS-1:0] level;
    } ctl_t;
endpackage

// File: rtl/pinov_sync.sv
module pinov_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[p]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[p] = chain_q[STAGES-1];

        // R8
        line_rise_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sync_o[p]) |-> $past(async_i[p], 2));
    end
endmodule

// File: rtl/pinov_regs.sv
module pinov_regs
    import pinov_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  line_lvl,
    output logic [DATA_W-1:0] rdata,
    output ctl_t              ctl
);
    localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(OFS_FUNC);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFS_DIN);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    ctl_t ctl_d, ctl_q;
    logic [NPINS-1:0] set_mask, clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        ctl_d    = ctl_q;
        if (wen) begin
            if (addr == A_FUNC) ctl_d.sw_own   = wdata[0];
            if (addr == A_DIR)  ctl_d.drive_en = wdata[NPINS-1:0];
            if (addr == A_SET)  set_mask       = wdata[NPINS-1:0];
            if (addr == A_CLR)  clr_mask       = wdata[NPINS-1:0];
        end
        ctl_d.level = (ctl_q.level | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_FUNC)      rdata[0]         = ctl_q.sw_own;
        else if (addr == A_DIR)  rdata[NPINS-1:0] = ctl_q.drive_en;
        else if (addr == A_DIN)  rdata[NPINS-1:0] = line_lvl;
        else if (addr == A_DOUT) rdata[NPINS-1:0] = ctl_q.level;
    end

    assign ctl = ctl_q;

    // R5
    set_bits_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == A_SET) |=> ((ctl_q.level & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

    // R6
    clr_bits_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == A_CLR) |=> ((ctl_q.level & $past(wdata[NPINS-1:0])) == '0));

    // R7
    dout_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && (addr == A_DOUT || addr == A_DIN)) |=> $stable(ctl_q));
endmodule

// File: rtl/pinov_mux.sv
module pinov_mux
    import pinov_pkg::*;
(
    input  ctl_t             ctl,
    input  logic [NPINS-1:0] eng_oe,
    output logic [NPINS-1:0] pin_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_comb begin
            if (ctl.sw_own) pin_oe[p] = ctl.drive_en[p] & ~ctl.level[p];
            else            pin_oe[p] = eng_oe[p];
        end
    end
endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
    import pinov_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_scl_oe,
    input  logic              eng_sda_oe,
    input  logic              pad_scl_i,
    input  logic              pad_sda_i,
    output logic              pad_scl_oe,
    output logic              pad_sda_oe
);
    ctl_t             ctl;
    logic [NPINS-1:0] line_lvl;
    logic [NPINS-1:0] pin_oe;
    logic [NPINS-1:0] eng_oe;
    logic [NPINS-1:0] pad_lvl;

    assign eng_oe  = {eng_sda_oe, eng_scl_oe};
    assign pad_lvl = {pad_sda_i, pad_scl_i};

    pinov_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_lvl),
        .sync_o  (line_lvl)
    );

    pinov_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (reg_wen),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .line_lvl (line_lvl),
        .rdata    (reg_rdata),
        .ctl      (ctl)
    );

    pinov_mux u_mux (
        .ctl    (ctl),
        .eng_oe (eng_oe),
        .pin_oe (pin_oe)
    );

    assign pad_scl_oe = pin_oe[PIN_SCL];
    assign pad_sda_oe = pin_oe[PIN_SDA];

    // R3
    sw_ignores_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sw_own && $stable(ctl)) |-> $stable(pin_oe));

    // R4
    undriven_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sw_own && !ctl.drive_en[PIN_SCL]) |-> !pad_scl_oe);

    // R10
    func_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_FUNC)) |-> (reg_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/i2c_pin_override_test.sv
module i2c_pin_override_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wen = 0;
    logic [7:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        eng_scl_oe = 0, eng_sda_oe = 0;
    logic        pad_scl_i = 1, pad_sda_i = 1;
    logic        pad_scl_oe, pad_sda_oe;

    int checks = 0;
    int failures = 0;
    string tag = "R1";
    bit done = 0;

    // behavioural reference state
    int m_own, m_dir, m_out;
    logic [1:0] m_hist[$];

    always #4 clk = ~clk;

    i2c_pin_override uut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
        .pad_scl_i(pad_scl_i), .pad_sda_i(pad_sda_i),
        .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_own = 0; m_dir = 0; m_out = 0;
            m_hist.delete();
        end else begin
            if (reg_wen) begin
                case (reg_addr)
                    8'h48: m_own = int'(reg_wdata[0]);
                    8'h4C: m_dir = int'(reg_wdata[1:0]);
                    8'h58: m_out = m_out | int'(reg_wdata[1:0]);
                    8'h5C: m_out = m_out & ~int'(reg_wdata[1:0]);
                    default: ;
                endcase
            end
            m_hist.push_back({pad_sda_i, pad_scl_i});
            if (m_hist.size() > 2) void'(m_hist.pop_front());
        end
    end

    function automatic int exp_oe(int pin, logic eng);
        if (m_own == 0) return int'(eng);
        return (((m_dir >> pin) & 1) == 1 && ((m_out >> pin) & 1) == 0) ? 1 : 0;
    endfunction

    function automatic int exp_rd();
        case (reg_addr)
            8'h48: return m_own;
            8'h4C: return m_dir;
            8'h50: return (m_hist.size() == 2) ? int'(m_hist[0]) : 0;
            8'h54: return m_out;
            default: return 0;
        endcase
    endfunction

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: compare at the falling edge, then present new inputs
    task automatic step(logic w, logic [7:0] a, logic [15:0] d,
                        logic escl, logic esda, logic pscl, logic psda);
        @(negedge clk);
        cmp("pad_scl_oe", int'(pad_scl_oe), exp_oe(0, eng_scl_oe));
        cmp("pad_sda_oe", int'(pad_sda_oe), exp_oe(1, eng_sda_oe));
        cmp("reg_rdata", int'(reg_rdata), exp_rd());
        reg_wen = w; reg_addr = a; reg_wdata = d;
        eng_scl_oe = escl; eng_sda_oe = esda;
        pad_scl_i = pscl; pad_sda_i = psda;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state with varied engine and pad inputs
        tag = "R1";
        step(0, 8'h48, 0, 1, 0, 0, 1);
        step(0, 8'h4C, 0, 0, 1, 1, 0);
        step(0, 8'h50, 0, 1, 1, 1, 1);
        @(negedge clk); rst_n = 1;
        step(0, 8'h54, 0, 0, 0, 1, 1);
        step(0, 8'h50, 0, 0, 0, 1, 1);

        // R2: engine ownership passes enables through
        tag = "R2";
        for (int k = 0; k < 4; k++) step(0, 8'h48, 0, k[0], k[1], 1, 1);
        step(1, 8'h4C, 16'h0003, 1, 0, 1, 1);   // direction written while engine owns pads
        step(0, 8'h4C, 0, 0, 1, 1, 1);
        step(0, 8'h4C, 0, 1, 1, 1, 1);

        // R3/R9: take over, engine enables toggle in the same cycle
        tag = "R3";
        step(1, 8'h48, 16'h0001, 0, 0, 1, 1);
        step(0, 8'h48, 0, 1, 0, 1, 1);
        step(0, 8'h48, 0, 0, 1, 1, 1);
        step(0, 8'h48, 0, 1, 1, 1, 1);

        // R5: set bits, zeros leave latch alone; read-in-write returns old value
        tag = "R5";
        step(1, 8'h58, 16'h0001, 0, 0, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);
        step(1, 8'h58, 16'h0000, 1, 1, 1, 1);
        step(0, 8'h54, 0, 1, 1, 1, 1);
        step(1, 8'h58, 16'hFFFE, 0, 0, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);

        // R6: clear bits
        tag = "R6";
        step(1, 8'h5C, 16'h0002, 0, 0, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);
        step(1, 8'h5C, 16'h0000, 0, 0, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);
        step(1, 8'h5C, 16'h0001, 0, 0, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);

        // R7: writes to data-out and data-in do nothing
        tag = "R7";
        step(1, 8'h54, 16'h0003, 1, 1, 1, 1);
        step(1, 8'h50, 16'hFFFF, 1, 1, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);
        step(0, 8'h54, 0, 0, 0, 1, 1);

        // R4: recovery setup, SCL driven, SDA released; clock SCL a few times
        tag = "R4";
        step(1, 8'h4C, 16'h0001, 1, 1, 1, 0);
        for (int k = 0; k < 3; k++) begin
            step(1, 8'h58, 16'h0001, 1, 1, 1, 0);
            step(1, 8'h5C, 16'h0001, 0, 1, 0, 0);
        end
        step(1, 8'h4C, 16'h0002, 1, 0, 0, 0);
        step(0, 8'h4C, 0, 0, 0, 0, 0);

        // R8: pad levels through the synchronizer
        tag = "R8";
        step(0, 8'h50, 0, 0, 0, 1, 0);
        step(0, 8'h50, 0, 0, 0, 0, 1);
        step(0, 8'h50, 0, 0, 0, 1, 1);
        step(0, 8'h50, 0, 0, 0, 1, 1);
        step(0, 8'h50, 0, 0, 0, 0, 0);
        step(0, 8'h50, 0, 0, 0, 0, 0);
        step(0, 8'h50, 0, 0, 0, 0, 0);

        // R9: set, clear and unmapped offsets read zero
        tag = "R9";
        step(0, 8'h58, 0, 0, 0, 1, 1);
        step(0, 8'h5C, 0, 0, 0, 1, 1);
        step(0, 8'h00, 0, 0, 0, 1, 1);
        step(1, 8'h4C, 16'h0003, 0, 0, 1, 1);
        step(0, 8'h4C, 0, 0, 0, 1, 1);

        // R10: upper bits discarded
        tag = "R10";
        step(1, 8'h48, 16'hFFFE, 1, 0, 1, 1);   // bit0 = 0 hands pads back
        step(0, 8'h48, 0, 0, 1, 1, 1);
        step(1, 8'h48, 16'hFFFF, 1, 1, 1, 1);
        step(1, 8'h4C, 16'hFFFC, 1, 1, 1, 1);
        step(0, 8'h4C, 0, 0, 0, 1, 1);
        step(0, 8'h48, 0, 0, 0, 1, 1);

        // R2: handing back to the engine
        tag = "R2";
        step(1, 8'h48, 16'h0000, 1, 0, 1, 1);
        step(0, 8'h48, 0, 0, 1, 1, 1);
        step(0, 8'h48, 0, 0, 0, 1, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule